// File: doc/BRIEF.md
# USB Host Bulk-IN Endpoint Controller

This block is the receive-side control for one bulk IN endpoint of a USB host. It decides when an IN token goes out toward a target device endpoint. It accepts the returned data packets into a buffer that holds one or two packets. It retries after NAK responses and can give up after a programmable number of frames. Everything below the token and handshake level is modelled by a simple link interface: a one-cycle token strobe out, and a NAK strobe or a byte stream with an end marker back. The PHY, CRC and bit stuffing are outside the block.

Software or a DMA engine unloads packets through a byte-wide read port. A pop pulse advances through the oldest packet, and a done pulse releases that packet's slot. With DMA enabled, a request line stays high while any complete packet is held, and the interrupt is kept for error conditions only. In CPU mode every completed packet raises the interrupt. With DMA enabled, an auto-request setting re-arms the IN request after each packet, so tokens continue without software.

Top module: `usb_bulk_in_ep`

## Requirements
- R1: The protocol field is `cfg_type[5:4]`, and only `2'b10` (bulk) is legal. Any other value drives `err_cfg` high one cycle later and blocks every IN token. Restoring `2'b10` lets a pending request issue a token.
- R2: A token is a one-cycle `tok_valid` pulse. It carries `tok_ep = cfg_type[3:0]` and `tok_speed = cfg_type[7:6]`. It is issued only while a request is pending, no earlier token is unanswered, no error is set and a packet slot is free.
- R3: With `cfg_dbl_buf = 0` the buffer holds one packet. While that packet is held no token is issued, and releasing it with `rd_done` lets a pending request go out.
- R4: With `cfg_dbl_buf = 1` the buffer holds two packets. A second token is issued while the first packet is still held, and packets are read out in arrival order.
- R5: A packet longer than `cfg_maxp` bytes, or longer than the `PKT_BYTES` storage, is discarded without changing `pkt_cnt`. It sets `err_ovr`, and tokens stop until the error is cleared.
- R6: After a NAK the token is re-issued. While NAKs continue, the NAK counter advances once per `frame_tick`. When the count reaches `cfg_nak_limit`, `err_nak` is set and no further token is issued.
- R7: A `cfg_nak_limit` of zero disables the timeout: `err_nak` never sets, however many NAKs and frame ticks arrive.
- R8: Any DATA response clears the NAK counter, so the limit counts only NAKs that follow one another without data in between.
- R9: With `cfg_dma_en = 1`, `dma_req` is high exactly while at least one complete packet is held. Packet completion does not raise `irq`, but errors still do.
- R10: With `cfg_dma_en = 0`, a held packet drives `pkt_rdy` and `irq` high and `dma_req` low. `rd_pop` steps through the bytes, `rd_len` gives the byte count, and `rd_done` frees the slot.
- R11: With DMA enabled and `cfg_autoreq` equal to `2'b01` or `2'b11`, the request stays armed after each received packet, so tokens continue without `sw_req`. Otherwise each `sw_req` yields a single packet.
- R12: `irq` is low whenever `cfg_int_en` is low, whatever the status.
- R13: An `err_clr` pulse clears `err_ovr`, `err_nak` and the NAK counter, and a still-pending request then issues a token again.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| cfg_type | input | 8 | Speed [7:6], protocol [5:4], target endpoint [3:0] |
| cfg_dbl_buf | input | 1 | Two-packet buffering enable |
| cfg_maxp | input | LEN_W | Maximum packet size in bytes |
| cfg_nak_limit | input | NAK_W | NAK-limit in frames; zero disables |
| cfg_dma_en | input | 1 | DMA mode enable |
| cfg_autoreq | input | 2 | Auto-request setting (used in DMA mode) |
| cfg_int_en | input | 1 | Endpoint interrupt enable |
| sw_req | input | 1 | Pulse: request one IN transfer |
| err_clr | input | 1 | Pulse: clear error flags and NAK counter |
| frame_tick | input | 1 | Pulse once per frame/microframe |
| tok_valid | output | 1 | IN token strobe |
| tok_ep | output | 4 | Target endpoint number for the token |
| tok_speed | output | 2 | Speed code for the token |
| lnk_nak | input | 1 | NAK handshake received |
| lnk_dvalid | input | 1 | Data byte valid |
| lnk_data | input | 8 | Data byte |
| lnk_dlast | input | 1 | Marks the final byte of a packet |
| rd_data | output | 8 | Current byte of the oldest packet |
| rd_len | output | LEN_W | Byte count of the oldest packet |
| rd_pop | input | 1 | Advance to the next byte |
| rd_done | input | 1 | Release the oldest packet |
| pkt_rdy | output | 1 | At least one packet held |
| pkt_cnt | output | 2 | Number of packets held |
| dma_req | output | 1 | DMA service request |
| irq | output | 1 | Endpoint interrupt |
| err_cfg | output | 1 | Protocol field not bulk |
| err_ovr | output | 1 | Oversize packet discarded |
| err_nak | output | 1 | NAK limit reached |

## Verification
The bench builds the block with `PKT_BYTES = 16` and the default 16-bit NAK counter. Small storage means an entry whose `cfg_maxp` exceeds the storage is cut at the storage edge, so both oversize paths of R5 can be reached with short packets. A NAK limit of 3 keeps the timeout, its reset by a DATA response, and its release by `err_clr` within a few dozen cycles. Both buffer depths and both DMA and CPU modes are exercised against the same link model.

// File: rtl/bulkin_pkg.sv
`timescale 1ns/1ps
package bulkin_pkg;
    localparam logic [1:0] PROT_BULK = 2'b10;
    localparam int SPD_HI  = 7;
    localparam int SPD_LO  = 6;
    localparam int PROT_HI = 5;
    localparam int PROT_LO = 4;
    localparam int EP_HI   = 3;
    localparam logic [1:0] SLOT_PAIR = 2'd2;
endpackage

// File: rtl/bulkin_rxbuf.sv
`timescale 1ns/1ps
module bulkin_rxbuf #(
    parameter int PKT_BYTES = 64,
    localparam int LEN_W = $clog2(PKT_BYTES + 1),
    localparam int IDX_W = $clog2(PKT_BYTES)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dbl,
    input  logic [LEN_W-1:0] maxp,
    input  logic             wr_valid,
    input  logic [7:0]       wr_data,
    input  logic             wr_last,
    input  logic             rd_pop,
    input  logic             rd_done,
    output logic [7:0]       rd_data,
    output logic [LEN_W-1:0] rd_len,
    output logic [1:0]       cnt,
    output logic             slot_free,
    output logic             commit,
    output logic             drop
);
    import bulkin_pkg::*;

    typedef struct packed {
        logic [1:0]            cnt;
        logic                  wr_slot;
        logic                  rd_slot;
        logic [LEN_W-1:0]      wr_cnt;
        logic                  wr_bad;
        logic [IDX_W-1:0]      rd_idx;
        logic [1:0][LEN_W-1:0] len;
    } buf_st_t;

    buf_st_t q, d;
    logic    byte_ok;
    logic    wr_en;
    logic    rel;
    logic [7:0] mem [2][PKT_BYTES];

    always_comb begin
        d       = q;
        commit  = 1'b0;
        drop    = 1'b0;
        byte_ok = (q.wr_cnt < maxp) && (q.wr_cnt < LEN_W'(PKT_BYTES));
        wr_en   = wr_valid && byte_ok;
        rel     = rd_done && (q.cnt != 2'd0);
        if (wr_valid) begin
            if (byte_ok) d.wr_cnt = q.wr_cnt + 1'b1;
            else         d.wr_bad = 1'b1;
            if (wr_last) begin
                d.wr_cnt = '0;
                d.wr_bad = 1'b0;
                if (q.wr_bad || !byte_ok) begin
                    drop = 1'b1;
                end else begin
                    commit            = 1'b1;
                    d.len[q.wr_slot]  = q.wr_cnt + 1'b1;
                    d.wr_slot         = ~q.wr_slot;
                end
            end
        end
        if (rd_pop && (q.cnt != 2'd0)) d.rd_idx = q.rd_idx + 1'b1;
        if (rel) begin
            d.rd_idx  = '0;
            d.rd_slot = ~q.rd_slot;
        end
        d.cnt = q.cnt + {1'b0, commit} - {1'b0, rel};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    always_ff @(posedge clk) begin
        if (wr_en) mem[q.wr_slot][q.wr_cnt[IDX_W-1:0]] <= wr_data;
    end

    assign rd_data   = mem[q.rd_slot][q.rd_idx];
    assign rd_len    = q.len[q.rd_slot];
    assign cnt       = q.cnt;
    assign slot_free = q.cnt < (dbl ? SLOT_PAIR : 2'd1);

    // R4
    no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
        commit |-> (q.cnt < SLOT_PAIR));

    // R5
    drop_keep_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (drop && !rd_done) |=> $stable(q.cnt));
endmodule

// File: rtl/bulkin_nak_timer.sv
`timescale 1ns/1ps
module bulkin_nak_timer #(
    parameter int NAK_W = 16
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [NAK_W-1:0] limit,
    input  logic             nak,
    input  logic             data_seen,
    input  logic             frame_tick,
    input  logic             clr,
    output logic             timeout
);
    typedef struct packed {
        logic             active;
        logic [NAK_W-1:0] cnt;
        logic             to;
    } nak_st_t;

    nak_st_t q, d;
    logic [NAK_W:0] next_cnt;

    always_comb begin
        d        = q;
        next_cnt = {1'b0, q.cnt} + 1'b1;
        if (frame_tick && q.active && !q.to && (limit != '0)) begin
            d.cnt = next_cnt[NAK_W-1:0];
            if (next_cnt >= {1'b0, limit}) d.to = 1'b1;
        end
        if (nak) d.active = 1'b1;
        if (data_seen) begin
            d.active = 1'b0;
            d.cnt    = '0;
        end
        if (clr) d = '0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign timeout = q.to;

    // R6
    to_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(q.to) |-> $past(frame_tick));

    // R7
    zero_limit_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ((limit == '0) && !q.to) |=> !q.to);
endmodule

// File: rtl/usb_bulk_in_ep.sv
`timescale 1ns/1ps
module usb_bulk_in_ep #(
    parameter int PKT_BYTES = 64,
    parameter int NAK_W = 16,
    localparam int LEN_W = $clog2(PKT_BYTES + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       cfg_type,
    input  logic             cfg_dbl_buf,
    input  logic [LEN_W-1:0] cfg_maxp,
    input  logic [NAK_W-1:0] cfg_nak_limit,
    input  logic             cfg_dma_en,
    input  logic [1:0]       cfg_autoreq,
    input  logic             cfg_int_en,
    input  logic             sw_req,
    input  logic             err_clr,
    input  logic             frame_tick,
    output logic             tok_valid,
    output logic [3:0]       tok_ep,
    output logic [1:0]       tok_speed,
    input  logic             lnk_nak,
    input  logic             lnk_dvalid,
    input  logic [7:0]       lnk_data,
    input  logic             lnk_dlast,
    output logic [7:0]       rd_data,
    output logic [LEN_W-1:0] rd_len,
    input  logic             rd_pop,
    input  logic             rd_done,
    output logic             pkt_rdy,
    output logic [1:0]       pkt_cnt,
    output logic             dma_req,
    output logic             irq,
    output logic             err_cfg,
    output logic             err_ovr,
    output logic             err_nak
);
    import bulkin_pkg::*;

    typedef struct packed {
        logic req;
        logic outst;
        logic tok;
        logic err_cfg;
        logic err_ovr;
    } ctl_st_t;

    ctl_st_t q, d;
    logic cfg_ok, auto_rearm, can_issue;
    logic slot_free, commit, drop, nak_to;
    logic [1:0] cnt;

    bulkin_rxbuf #(.PKT_BYTES(PKT_BYTES)) u_rxbuf (
        .clk       (clk),
        .rst_n     (rst_n),
        .dbl       (cfg_dbl_buf),
        .maxp      (cfg_maxp),
        .wr_valid  (lnk_dvalid),
        .wr_data   (lnk_data),
        .wr_last   (lnk_dlast),
        .rd_pop    (rd_pop),
        .rd_done   (rd_done),
        .rd_data   (rd_data),
        .rd_len    (rd_len),
        .cnt       (cnt),
        .slot_free (slot_free),
        .commit    (commit),
        .drop      (drop)
    );

    bulkin_nak_timer #(.NAK_W(NAK_W)) u_nak (
        .clk        (clk),
        .rst_n      (rst_n),
        .limit      (cfg_nak_limit),
        .nak        (lnk_nak),
        .data_seen  (lnk_dvalid),
        .frame_tick (frame_tick),
        .clr        (err_clr),
        .timeout    (nak_to)
    );

    always_comb begin
        d          = q;
        cfg_ok     = (cfg_type[PROT_HI:PROT_LO] == PROT_BULK);
        auto_rearm = cfg_dma_en && ((cfg_autoreq == 2'b01) || (cfg_autoreq == 2'b11));
        can_issue  = q.req && !q.outst && !q.tok && slot_free && cfg_ok
                     && !nak_to && !q.err_ovr;
        d.err_cfg  = !cfg_ok;
        d.tok      = can_issue;
        if (can_issue) d.outst = 1'b1;
        if (lnk_nak) d.outst = 1'b0;
        if (lnk_dvalid && lnk_dlast) begin
            d.outst = 1'b0;
            d.req   = auto_rearm;
        end
        if (drop) d.err_ovr = 1'b1;
        if (sw_req) d.req = 1'b1;
        if (err_clr) d.err_ovr = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) q <= '0;
        else        q <= d;
    end

    assign tok_valid = q.tok;
    assign tok_ep    = cfg_type[EP_HI:0];
    assign tok_speed = cfg_type[SPD_HI:SPD_LO];
    assign pkt_cnt   = cnt;
    assign pkt_rdy   = (cnt != 2'd0);
    assign dma_req   = cfg_dma_en && pkt_rdy;
    assign err_cfg   = q.err_cfg;
    assign err_ovr   = q.err_ovr;
    assign err_nak   = nak_to;
    assign irq       = cfg_int_en &&
                       (q.err_cfg || q.err_ovr || nak_to || (!cfg_dma_en && pkt_rdy));

    // R1
    cfg_block_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.err_cfg |-> !q.tok);

    // R2
    tok_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.tok |=> !q.tok);

    // R3
    tok_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
        q.tok |-> (cnt < (cfg_dbl_buf ? SLOT_PAIR : 2'd1)));

    // R6
    nak_stop_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (nak_to && $past(nak_to)) |-> !q.tok);
endmodule

// File: tb/usb_bulk_in_ep_tb.sv
`timescale 1ns/1ps
module usb_bulk_in_ep_tb;
    localparam int PKT_BYTES = 16;
    localparam int NAK_W = 16;
    localparam int LEN_W = $clog2(PKT_BYTES + 1);

    // maxp, packet length, 1 = accepted / 0 = oversize
    localparam int VEC [6][3] = '{
        '{8, 8, 1}, '{8, 9, 0}, '{8, 1, 1},
        '{16, 16, 1}, '{20, 17, 0}, '{12, 5, 1}
    };

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic [7:0] cfg_type = 8'hA5;
    logic cfg_dbl_buf = 1'b0;
    logic [LEN_W-1:0] cfg_maxp = LEN_W'(16);
    logic [NAK_W-1:0] cfg_nak_limit = '0;
    logic cfg_dma_en = 1'b0;
    logic [1:0] cfg_autoreq = 2'b00;
    logic cfg_int_en = 1'b1;
    logic sw_req = 1'b0, err_clr = 1'b0, frame_tick = 1'b0;
    logic lnk_nak = 1'b0, lnk_dvalid = 1'b0, lnk_dlast = 1'b0;
    logic [7:0] lnk_data = 8'h00;
    logic rd_pop = 1'b0, rd_done = 1'b0;
    logic tok_valid, pkt_rdy, dma_req, irq, err_cfg, err_ovr, err_nak;
    logic [3:0] tok_ep;
    logic [1:0] tok_speed, pkt_cnt;
    logic [7:0] rd_data;
    logic [LEN_W-1:0] rd_len;

    int n_chk = 0;
    int n_err = 0;
    bit got;

    always #2.5 clk = ~clk;

    usb_bulk_in_ep #(.PKT_BYTES(PKT_BYTES), .NAK_W(NAK_W)) u_dut (
        .clk(clk), .rst_n(rst_n), .cfg_type(cfg_type), .cfg_dbl_buf(cfg_dbl_buf),
        .cfg_maxp(cfg_maxp), .cfg_nak_limit(cfg_nak_limit), .cfg_dma_en(cfg_dma_en),
        .cfg_autoreq(cfg_autoreq), .cfg_int_en(cfg_int_en), .sw_req(sw_req),
        .err_clr(err_clr), .frame_tick(frame_tick), .tok_valid(tok_valid),
        .tok_ep(tok_ep), .tok_speed(tok_speed), .lnk_nak(lnk_nak),
        .lnk_dvalid(lnk_dvalid), .lnk_data(lnk_data), .lnk_dlast(lnk_dlast),
        .rd_data(rd_data), .rd_len(rd_len), .rd_pop(rd_pop), .rd_done(rd_done),
        .pkt_rdy(pkt_rdy), .pkt_cnt(pkt_cnt), .dma_req(dma_req), .irq(irq),
        .err_cfg(err_cfg), .err_ovr(err_ovr), .err_nak(err_nak)
    );

    task automatic chk(input string tag, input int act, input int exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
        end
    endtask

    task automatic wait_tok(output bit seen);
        seen = 1'b0;
        for (int i = 0; i < 20; i++) begin
            @(negedge clk);
            if (tok_valid) begin
                seen = 1'b1;
                break;
            end
        end
    endtask

    task automatic pulse_req();
        sw_req = 1'b1;
        @(negedge clk);
        sw_req = 1'b0;
    endtask

    task automatic pulse_clr();
        err_clr = 1'b1;
        @(negedge clk);
        err_clr = 1'b0;
    endtask

    task automatic send_pkt(input int len, input int base);
        for (int i = 0; i < len; i++) begin
            lnk_dvalid = 1'b1;
            lnk_data   = 8'(base + i);
            lnk_dlast  = (i == len - 1);
            @(negedge clk);
        end
        lnk_dvalid = 1'b0;
        lnk_dlast  = 1'b0;
    endtask

    task automatic send_nak(input bit tick);
        lnk_nak    = 1'b1;
        frame_tick = tick;
        @(negedge clk);
        lnk_nak    = 1'b0;
        frame_tick = 1'b0;
    endtask

    task automatic read_pkt(input string tag, input int len, input int base);
        chk({tag, " rd_len"}, int'(rd_len), len);
        for (int i = 0; i < len; i++) begin
            chk({tag, " rd_data"}, int'(rd_data), (base + i) & 8'hFF);
            rd_pop = 1'b1;
            @(negedge clk);
        end
        rd_pop  = 1'b0;
        rd_done = 1'b1;
        @(negedge clk);
        rd_done = 1'b0;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_err++;
        $display("FAIL watchdog: actual 1 expected 0");
        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // reset state (R2, R9, R10, R12)
        chk("R2 reset tok_valid", int'(tok_valid), 0);
        chk("R10 reset pkt_cnt", int'(pkt_cnt), 0);
        chk("R9 reset dma_req", int'(dma_req), 0);
        chk("R12 reset irq", int'(irq), 0);
        chk("R5 reset err_ovr", int'(err_ovr), 0);
        chk("R1 reset err_cfg", int'(err_cfg), 0);

        // vector table: packet size against maxp and storage (R5, R10)
        for (int v = 0; v < 6; v++) begin
            cfg_maxp = LEN_W'(VEC[v][0]);
            pulse_req();
            wait_tok(got);
            chk("R2 table token", int'(got), 1);
            chk("R2 tok_ep", int'(tok_ep), 5);
            chk("R2 tok_speed", int'(tok_speed), 2);
            send_pkt(VEC[v][1], 16 * v);
            chk("R5 table pkt_cnt", int'(pkt_cnt), VEC[v][2]);
            chk("R5 table err_ovr", int'(err_ovr), 1 - VEC[v][2]);
            if (VEC[v][2] == 1) begin
                read_pkt("R10 table", VEC[v][1], 16 * v);
            end else begin
                wait_tok(got);
                chk("R5 no token after oversize", int'(got), 0);
                pulse_clr();
                chk("R13 err_ovr cleared", int'(err_ovr), 0);
            end
        end
        cfg_maxp = LEN_W'(16);

        // CPU mode packet, interrupt gating (R10, R12)
        pulse_req();
        wait_tok(got);
        chk("R10 token", int'(got), 1);
        send_pkt(4, 8'h40);
        chk("R10 pkt_rdy", int'(pkt_rdy), 1);
        chk("R10 irq", int'(irq), 1);
        chk("R10 dma_req low", int'(dma_req), 0);
        cfg_int_en = 1'b0;
        @(negedge clk);
        chk("R12 irq gated", int'(irq), 0);
        chk("R12 pkt still held", int'(pkt_rdy), 1);
        cfg_int_en = 1'b1;
        read_pkt("R10 cpu", 4, 8'h40);
        chk("R10 pkt_rdy cleared", int'(pkt_rdy), 0);
        chk("R10 irq cleared", int'(irq), 0);
        wait_tok(got);
        chk("R11 one packet per request", int'(got), 0);

        // single buffer (R3)
        pulse_req();
        wait_tok(got);
        send_pkt(2, 8'h50);
        pulse_req();
        wait_tok(got);
        chk("R3 no token while full", int'(got), 0);
        read_pkt("R3 first", 2, 8'h50);
        wait_tok(got);
        chk("R3 token after release", int'(got), 1);
        send_pkt(3, 8'h58);
        read_pkt("R3 second", 3, 8'h58);

        // double buffer (R4)
        cfg_dbl_buf = 1'b1;
        pulse_req();
        wait_tok(got);
        send_pkt(3, 8'h60);
        pulse_req();
        wait_tok(got);
        chk("R4 second token while held", int'(got), 1);
        send_pkt(4, 8'h70);
        chk("R4 two packets", int'(pkt_cnt), 2);
        pulse_req();
        wait_tok(got);
        chk("R4 no token when both full", int'(got), 0);
        read_pkt("R4 first in order", 3, 8'h60);
        wait_tok(got);
        chk("R4 token after one released", int'(got), 1);
        send_pkt(2, 8'h80);
        read_pkt("R4 second in order", 4, 8'h70);
        read_pkt("R4 third in order", 2, 8'h80);

        // DMA mode (R9)
        cfg_dbl_buf = 1'b0;
        cfg_dma_en  = 1'b1;
        pulse_req();
        wait_tok(got);
        send_pkt(5, 8'h90);
        chk("R9 dma_req", int'(dma_req), 1);
        chk("R9 no packet irq", int'(irq), 0);
        read_pkt("R9 dma read", 5, 8'h90);
        chk("R9 dma_req drops", int'(dma_req), 0);
        pulse_req();
        wait_tok(got);
        send_pkt(17, 8'hA0);
        chk("R9 error irq in dma", int'(irq), 1);
        chk("R5 oversize in dma", int'(err_ovr), 1);
        chk("R5 oversize not stored", int'(pkt_cnt), 0);
        pulse_clr();
        chk("R13 irq after clear", int'(irq), 0);

        // auto-request (R11)
        cfg_dbl_buf = 1'b1;
        cfg_autoreq = 2'b01;
        pulse_req();
        wait_tok(got);
        send_pkt(2, 8'hB0);
        wait_tok(got);
        chk("R11 auto token", int'(got), 1);
        send_pkt(2, 8'hB4);
        wait_tok(got);
        chk("R11 auto stops when full", int'(got), 0);
        cfg_autoreq = 2'b00;
        read_pkt("R11 first", 2, 8'hB0);
        wait_tok(got);
        chk("R11 armed token after release", int'(got), 1);
        send_pkt(1, 8'hB8);
        read_pkt("R11 second", 2, 8'hB4);
        read_pkt("R11 third", 1, 8'hB8);
        wait_tok(got);
        chk("R11 no auto with 00", int'(got), 0);
        cfg_dma_en  = 1'b0;
        cfg_dbl_buf = 1'b0;

        // protocol field check (R1)
        cfg_type = 8'h95;
        @(negedge clk);
        chk("R1 err_cfg", int'(err_cfg), 1);
        chk("R1 err_cfg irq", int'(irq), 1);
        pulse_req();
        wait_tok(got);
        chk("R1 no token", int'(got), 0);
        cfg_type = 8'hA5;
        wait_tok(got);
        chk("R1 token after fix", int'(got), 1);
        chk("R1 err_cfg cleared", int'(err_cfg), 0);
        send_pkt(2, 8'hC0);
        read_pkt("R1 data", 2, 8'hC0);

        // NAK limit, reset by data, clear (R6, R8, R13)
        cfg_nak_limit = NAK_W'(3);
        pulse_req();
        for (int k = 0; k < 3; k++) begin
            wait_tok(got);
            chk("R6 token retried after NAK", int'(got), 1);
            send_nak(1'b1);
        end
        chk("R8 no timeout before data", int'(err_nak), 0);
        wait_tok(got);
        send_pkt(2, 8'hD0);
        read_pkt("R8 data", 2, 8'hD0);
        pulse_req();
        for (int k = 0; k < 3; k++) begin
            wait_tok(got);
            chk("R8 token", int'(got), 1);
            send_nak(1'b1);
        end
        chk("R8 counter was reset by data", int'(err_nak), 0);
        wait_tok(got);
        send_nak(1'b1);
        chk("R6 err_nak at limit", int'(err_nak), 1);
        chk("R6 error irq", int'(irq), 1);
        wait_tok(got);
        chk("R6 tokens stop", int'(got), 0);
        pulse_clr();
        chk("R13 err_nak cleared", int'(err_nak), 0);
        wait_tok(got);
        chk("R13 token resumes", int'(got), 1);
        send_pkt(3, 8'hE0);
        read_pkt("R13 data", 3, 8'hE0);

        // limit zero (R7)
        cfg_nak_limit = '0;
        pulse_req();
        for (int k = 0; k < 6; k++) begin
            wait_tok(got);
            chk("R7 token keeps coming", int'(got), 1);
            send_nak(1'b1);
        end
        chk("R7 no timeout", int'(err_nak), 0);
        wait_tok(got);
        send_pkt(1, 8'hF0);
        read_pkt("R7 data", 1, 8'hF0);

        $display("Simulation finished: %0d checks, %0d errors", n_chk, n_err);
        $finish;
    end
endmodule